// File: doc/BRIEF.md
# Time-Triggered Schedule Entry Sequencer

This block reads a short list of schedule entries from an external synchronous memory once per pass and turns them into the active schedule settings of one time-triggered bus node. A pass begins with a start pulse. The sequencer then fetches entries one at a time from address 0 upward. For each entry it checks that the entry is allowed in that position of the list. If the entry is allowed, its payload is written into the setting that its type controls. A later entry of the same kind replaces the value left by an earlier one.

The list grammar depends on the node role. A time master must pair every reference-message entry with a cycle-end entry. A slave needs only cycle-end entries. Every list must be closed by a cycle-end entry whose gap flag is 0.

While the node is in a gap, entries that carry the gap flag are passed over. The reference entry without the flag then sets up an emergency reference message instead of the normal one. That emergency message is requested once the synchronisation timeout input rises. Any grammar violation stops the walk and raises a sticky error flag.

Top module: `tt_sched_walk`

## Requirements
- R1: The entry word is {payload[PW-1:0], gap flag at bit 3, type at bits 2:0}. The type codes are: 0 time mark, 1 receive window, 2 idle window, 3 transmit window, 4 arbitration window, 5 reference message, 6 cycle end, 7 illegal. A start pulse while not busy begins a pass. The pass reads addresses 0, 1, 2, … in order, one read per entry. The read data is taken in the cycle after `rd_en`. The start pulse also clears `done` and `seq_err`.
- R2: A window entry (codes 1–4) that comes before any time-mark entry in the pass ends the walk with `seq_err`.
- R3: For a time master, a reference entry must be followed directly by a cycle-end entry with the same gap flag. A cycle-end entry that has no open reference entry ends the walk with `seq_err`. So does any other entry placed after a reference entry.
- R4: For a slave (`is_master`=0), a reference entry ends the walk with `seq_err`. A cycle-end entry is accepted at any position.
- R5: An accepted cycle-end entry with gap flag 0 ends the pass with `done`. An entry of type 7 ends the walk with `seq_err`.
- R6: If the entry at address DEPTH-1 is accepted but does not close the list, the walk ends with `seq_err`.
- R7: Each setting output holds the payload of the last accepted entry of its kind. The window kind records the type code of the last accepted window entry. All setting outputs keep their values outside a pass and across passes.
- R8: `in_gap` is sampled at the start of the pass. While it is set, reference and cycle-end entries with gap flag 1 change no setting. While it is clear, they update `cfg_ref` and `cfg_cycle`.
- R9: While in a gap, a reference entry with gap flag 0 loads `emerg_ref` and leaves `cfg_ref` unchanged. It also arms an emergency request. While armed, `emerg_req` is high in the cycle after each cycle where `sync_timeout` is high. The next start disarms the request.
- R10: `seq_err` stays set, and the settings stay unchanged, until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a pass when not busy |
| is_master | input | 1 | 1 = time master grammar, 0 = slave grammar |
| in_gap | input | 1 | Node is in a gap (sampled at start) |
| sync_timeout | input | 1 | Synchronisation event overdue |
| rd_en | output | 1 | Entry read strobe |
| rd_addr | output | AW | Entry address |
| rd_data | input | PW+4 | Entry word, valid the cycle after rd_en |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Last pass closed correctly |
| seq_err | output | 1 | Sticky sequence error of last pass |
| cfg_mark | output | PW | Time-mark setting |
| cfg_win | output | PW | Window setting |
| cfg_win_kind | output | 3 | Type code of last window entry |
| cfg_ref | output | PW | Normal reference setting |
| cfg_cycle | output | PW | Cycle-end setting |
| emerg_ref | output | PW | Emergency reference setting |
| emerg_req | output | 1 | Emergency reference request |

## Verification
The bench runs lists that close correctly for each role. It also runs lists that break one grammar rule at a time: a window entry before a time mark, an unpaired cycle end, a non-cycle-end entry after an open reference, a gap-flag mismatch, a slave reference entry, an illegal code, and a list with no terminator. Together these show that each rule stops the walk on its own. The same flagged entries are run both inside and outside a gap, which shows the skip rule apart from the update rule. Repeated entries of one kind show that the later payload replaces the earlier one. A gap pass with a reference entry of flag 0 is followed by timeout pulses and then a fresh start, which shows how the emergency request is armed, when it fires, and when it is disarmed.

// File: rtl/tt_sched_pkg.sv
package tt_sched_pkg;
    typedef enum logic [2:0] {
        ENT_TMARK  = 3'd0,
        ENT_RXWIN  = 3'd1,
        ENT_IDWIN  = 3'd2,
        ENT_TXWIN  = 3'd3,
        ENT_ARBWIN = 3'd4,
        ENT_REFMSG = 3'd5,
        ENT_CYCEND = 3'd6,
        ENT_BAD    = 3'd7
    } ent_kind_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_CHECK = 3'd2,
        S_APPLY = 3'd3,
        S_DONE  = 3'd4,
        S_ERROR = 3'd5
    } seq_state_e;
endpackage

// File: rtl/tt_seq_rules.sv
module tt_seq_rules
    import tt_sched_pkg::*;
(
    input  ent_kind_e kind,
    input  logic      gapf,
    input  logic      is_master,
    input  logic      mark_seen,
    input  logic      ref_open,
    input  logic      ref_gapf,
    output logic      legal,
    output logic      closes
);
    always_comb begin
        legal = 1'b0;
        unique case (kind)
            ENT_TMARK:  legal = !ref_open;
            ENT_RXWIN, ENT_IDWIN, ENT_TXWIN, ENT_ARBWIN:
                        legal = mark_seen && !ref_open;
            ENT_REFMSG: legal = is_master && !ref_open;
            ENT_CYCEND: legal = is_master ? (ref_open && (gapf == ref_gapf)) : 1'b1;
            default:    legal = 1'b0;
        endcase
        closes = legal && (kind == ENT_CYCEND) && !gapf;
    end
endmodule

// File: rtl/tt_cfg_bank.sv
module tt_cfg_bank
    import tt_sched_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          apply,
    input  ent_kind_e     kind,
    input  logic          gapf,
    input  logic [PW-1:0] payload,
    input  logic          gap,
    input  logic          sync_timeout,
    output logic [PW-1:0] cfg_mark,
    output logic [PW-1:0] cfg_win,
    output logic [2:0]    cfg_win_kind,
    output logic [PW-1:0] cfg_ref,
    output logic [PW-1:0] cfg_cycle,
    output logic [PW-1:0] emerg_ref,
    output logic          emerg_req
);
    typedef struct packed {
        logic [PW-1:0] mark;
        logic [PW-1:0] win;
        logic [2:0]    wkind;
        logic [PW-1:0] refm;
        logic [PW-1:0] cyc;
        logic [PW-1:0] eref;
        logic          arm;
        logic          req;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d     = bank_q;
        bank_d.req = bank_q.arm && sync_timeout;
        if (clear) bank_d.arm = 1'b0;
        if (apply) begin
            unique case (kind)
                ENT_TMARK: bank_d.mark = payload;
                ENT_RXWIN, ENT_IDWIN, ENT_TXWIN, ENT_ARBWIN: begin
                    bank_d.win   = payload;
                    bank_d.wkind = kind;
                end
                ENT_REFMSG: begin
                    if (gapf) begin
                        if (!gap) bank_d.refm = payload;
                    end else if (gap) begin
                        bank_d.eref = payload;
                        bank_d.arm  = 1'b1;
                    end else begin
                        bank_d.refm = payload;
                    end
                end
                ENT_CYCEND: if (!gapf || !gap) bank_d.cyc = payload;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign cfg_mark     = bank_q.mark;
    assign cfg_win      = bank_q.win;
    assign cfg_win_kind = bank_q.wkind;
    assign cfg_ref      = bank_q.refm;
    assign cfg_cycle    = bank_q.cyc;
    assign emerg_ref    = bank_q.eref;
    assign emerg_req    = bank_q.req;
endmodule

// File: rtl/tt_sched_walk.sv
module tt_sched_walk
    import tt_sched_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int EW   = PW + 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_master,
    input  logic          in_gap,
    input  logic          sync_timeout,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [EW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic          seq_err,
    output logic [PW-1:0] cfg_mark,
    output logic [PW-1:0] cfg_win,
    output logic [2:0]    cfg_win_kind,
    output logic [PW-1:0] cfg_ref,
    output logic [PW-1:0] cfg_cycle,
    output logic [PW-1:0] emerg_ref,
    output logic          emerg_req
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [AW-1:0] idx;
        ent_kind_e     ent_kind;
        logic          ent_gapf;
        logic [PW-1:0] ent_pay;
        logic          closes;
        logic          mark_seen;
        logic          ref_open;
        logic          ref_gapf;
        logic          gap;
    } walk_t;

    walk_t walk_d, walk_q;

    ent_kind_e rd_kind;
    logic      rule_legal, rule_closes, launch;

    assign rd_kind = ent_kind_e'(rd_data[2:0]);
    assign busy    = (walk_q.state == S_FETCH) || (walk_q.state == S_CHECK) ||
                     (walk_q.state == S_APPLY);
    assign launch  = start && !busy;

    tt_seq_rules u_rules (
        .kind      (rd_kind),
        .gapf      (rd_data[3]),
        .is_master (is_master),
        .mark_seen (walk_q.mark_seen),
        .ref_open  (walk_q.ref_open),
        .ref_gapf  (walk_q.ref_gapf),
        .legal     (rule_legal),
        .closes    (rule_closes)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            S_IDLE, S_DONE, S_ERROR: begin
                if (start) begin
                    walk_d.state     = S_FETCH;
                    walk_d.idx       = '0;
                    walk_d.mark_seen = 1'b0;
                    walk_d.ref_open  = 1'b0;
                    walk_d.ref_gapf  = 1'b0;
                    walk_d.gap       = in_gap;
                end
            end
            S_FETCH: walk_d.state = S_CHECK;
            S_CHECK: begin
                walk_d.ent_kind = rd_kind;
                walk_d.ent_gapf = rd_data[3];
                walk_d.ent_pay  = rd_data[EW-1:4];
                walk_d.closes   = rule_closes;
                walk_d.state    = rule_legal ? S_APPLY : S_ERROR;
            end
            S_APPLY: begin
                if (walk_q.ent_kind == ENT_TMARK) walk_d.mark_seen = 1'b1;
                if (walk_q.ent_kind == ENT_REFMSG) begin
                    walk_d.ref_open = 1'b1;
                    walk_d.ref_gapf = walk_q.ent_gapf;
                end
                if (walk_q.ent_kind == ENT_CYCEND) walk_d.ref_open = 1'b0;
                if (walk_q.closes) begin
                    walk_d.state = S_DONE;
                end else if (walk_q.idx == LAST) begin
                    walk_d.state = S_ERROR;
                end else begin
                    walk_d.idx   = walk_q.idx + 1'b1;
                    walk_d.state = S_FETCH;
                end
            end
            default: walk_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign rd_en   = (walk_q.state == S_FETCH);
    assign rd_addr = walk_q.idx;
    assign done    = (walk_q.state == S_DONE);
    assign seq_err = (walk_q.state == S_ERROR);

    tt_cfg_bank #(.PW(PW)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (launch),
        .apply        (walk_q.state == S_APPLY),
        .kind         (walk_q.ent_kind),
        .gapf         (walk_q.ent_gapf),
        .payload      (walk_q.ent_pay),
        .gap          (walk_q.gap),
        .sync_timeout (sync_timeout),
        .cfg_mark     (cfg_mark),
        .cfg_win      (cfg_win),
        .cfg_win_kind (cfg_win_kind),
        .cfg_ref      (cfg_ref),
        .cfg_cycle    (cfg_cycle),
        .emerg_ref    (emerg_ref),
        .emerg_req    (emerg_req)
    );
endmodule

// File: rtl/tt_sched_walk_chk.sv
module tt_sched_walk_chk #(
    parameter int DEPTH = 8,
    parameter int PW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          sync_timeout,
    input logic          rd_en,
    input logic [AW-1:0] rd_addr,
    input logic          busy,
    input logic          done,
    input logic          seq_err,
    input logic [PW-1:0] cfg_mark,
    input logic [PW-1:0] cfg_win,
    input logic [PW-1:0] cfg_ref,
    input logic [PW-1:0] cfg_cycle,
    input logic [PW-1:0] emerg_ref,
    input logic          emerg_req
);
    assert_start_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (rd_en && rd_addr == '0 && !seq_err && !done));

    assert_one_read_per_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (busy && !rd_en));

    assert_done_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !start) |=> (seq_err && $stable(cfg_mark) && $stable(cfg_ref)
                                 && $stable(cfg_cycle) && $stable(cfg_win)));

    assert_cfg_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(cfg_mark) && $stable(cfg_win) && $stable(cfg_ref)
                   && $stable(cfg_cycle) && $stable(emerg_ref)));

    assert_emerg_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        emerg_req |-> $past(sync_timeout));
endmodule

bind tt_sched_walk tt_sched_walk_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .sync_timeout (sync_timeout),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .busy         (busy),
    .done         (done),
    .seq_err      (seq_err),
    .cfg_mark     (cfg_mark),
    .cfg_win      (cfg_win),
    .cfg_ref      (cfg_ref),
    .cfg_cycle    (cfg_cycle),
    .emerg_ref    (emerg_ref),
    .emerg_req    (emerg_req)
);

// File: tb/tt_sched_walk_test.sv
`timescale 1ns/1ps
module tt_sched_walk_test;
    localparam int DEPTH = 8;
    localparam int PW    = 8;
    localparam int AW    = 3;
    localparam int EW    = PW + 4;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic is_master = 1'b0, in_gap = 1'b0, sync_timeout = 1'b0;
    logic rd_en, busy, done, seq_err, emerg_req;
    logic [AW-1:0] rd_addr;
    logic [EW-1:0] rd_data = '0;
    logic [PW-1:0] cfg_mark, cfg_win, cfg_ref, cfg_cycle, emerg_ref;
    logic [2:0] cfg_win_kind;

    logic [EW-1:0] mem [DEPTH];

    int total = 0, bad = 0;
    bit finished = 0;

    // model of the settings, from the requirements
    logic [PW-1:0] m_mark = 0, m_win = 0, m_ref = 0, m_cyc = 0, m_eref = 0;
    logic [2:0] m_kind = 0;

    typedef struct packed {
        logic          err;
        logic [PW-1:0] mark, win, refv, cyc, eref;
        logic [2:0]    kind;
    } exp_t;
    exp_t exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    tt_sched_walk #(.DEPTH(DEPTH), .PW(PW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_master(is_master),
        .in_gap(in_gap), .sync_timeout(sync_timeout), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
        .seq_err(seq_err), .cfg_mark(cfg_mark), .cfg_win(cfg_win),
        .cfg_win_kind(cfg_win_kind), .cfg_ref(cfg_ref), .cfg_cycle(cfg_cycle),
        .emerg_ref(emerg_ref), .emerg_req(emerg_req)
    );

    task automatic chk(string tag, string what, int act, int expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic clear_list();
        for (int i = 0; i < DEPTH; i++) mem[i] = {8'h00, 1'b0, 3'd7};
    endtask

    task automatic put(int i, int k, bit g, int p);
        mem[i] = {p[7:0], g, k[2:0]};
    endtask

    // R1..R9 reference walk on the bench copy of the list
    task automatic model_pass(bit master, bit gap, output bit err);
        bit seen = 0, open = 0, ogm = 0;
        err = 1;
        for (int i = 0; i < DEPTH; i++) begin
            logic [2:0] k;
            logic g;
            logic [7:0] p;
            bit ok;
            k = mem[i][2:0]; g = mem[i][3]; p = mem[i][11:4];
            case (k)
                3'd0: ok = !open;
                3'd1, 3'd2, 3'd3, 3'd4: ok = seen && !open;
                3'd5: ok = master && !open;
                3'd6: ok = master ? (open && g == ogm) : 1'b1;
                default: ok = 0;
            endcase
            if (!ok) return;
            case (k)
                3'd0: begin m_mark = p; seen = 1; end
                3'd1, 3'd2, 3'd3, 3'd4: begin m_win = p; m_kind = k; end
                3'd5: begin
                    open = 1; ogm = g;
                    if (g) begin if (!gap) m_ref = p; end
                    else if (gap) m_eref = p;
                    else m_ref = p;
                end
                3'd6: begin open = 0; if (!g || !gap) m_cyc = p; end
                default: ;
            endcase
            if (k == 3'd6 && !g) begin err = 0; return; end
        end
    endtask

    task automatic run_pass(string tag, bit master, bit gap);
        bit e;
        exp_t x;
        model_pass(master, gap, e);
        x.err = e; x.mark = m_mark; x.win = m_win; x.refv = m_ref;
        x.cyc = m_cyc; x.eref = m_eref; x.kind = m_kind;
        exp_q.push_back(x);
        tag_q.push_back(tag);
        is_master = master; in_gap = gap;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: compares each finished pass with the head of the queue
    initial begin
        bit pb = 0;
        forever begin
            @(negedge clk);
            if (pb && !busy) begin
                if (exp_q.size() == 0) begin
                    chk("R1", "unexpected pass end", 1, 0);
                end else begin
                    exp_t x;
                    string t;
                    x = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, "seq_err", seq_err, x.err);
                    chk(t, "done", done, !x.err);
                    chk(t, "cfg_mark", cfg_mark, x.mark);
                    chk(t, "cfg_win", cfg_win, x.win);
                    chk(t, "cfg_win_kind", cfg_win_kind, x.kind);
                    chk(t, "cfg_ref", cfg_ref, x.refv);
                    chk(t, "cfg_cycle", cfg_cycle, x.cyc);
                    chk(t, "emerg_ref", emerg_ref, x.eref);
                end
            end
            pb = busy;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_list();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R1, R7)
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset rd_en", rd_en, 0);
        chk("R5", "reset done", done, 0);
        chk("R10", "reset seq_err", seq_err, 0);
        chk("R7", "reset cfg_mark", cfg_mark, 0);
        chk("R9", "reset emerg_req", emerg_req, 0);

        // R4 R5 R7: slave list closes normally
        clear_list();
        put(0, 0, 0, 8'h10); put(1, 1, 0, 8'h21); put(2, 6, 0, 8'h32);
        run_pass("R4_slave_ok", 0, 0);

        // R7: later entries overwrite earlier ones
        clear_list();
        put(0, 0, 0, 8'hA1); put(1, 0, 0, 8'hA2); put(2, 4, 0, 8'hB1);
        put(3, 1, 0, 8'hB2); put(4, 6, 0, 8'hC1);
        run_pass("R7_overwrite", 0, 0);

        // R3 R5: master full closing sequence outside a gap
        clear_list();
        put(0, 0, 0, 8'h01); put(1, 2, 0, 8'h02); put(2, 3, 0, 8'h03);
        put(3, 5, 1, 8'h44); put(4, 6, 1, 8'h55); put(5, 5, 0, 8'h66);
        put(6, 6, 0, 8'h77);
        run_pass("R3_master_close", 1, 0);

        // R8: flagged entries applied outside a gap (pass ends on code 7)
        clear_list();
        put(0, 5, 1, 8'h11); put(1, 6, 1, 8'h22);
        run_pass("R8_flag_nogap", 1, 0);

        // R8: same flagged entries skipped inside a gap
        clear_list();
        put(0, 5, 1, 8'h91); put(1, 6, 1, 8'h92);
        run_pass("R8_flag_gap", 1, 1);

        // R8: slave in a gap, flagged cycle end skipped, closing one applied
        clear_list();
        put(0, 6, 1, 8'hD1); put(1, 6, 0, 8'hD2);
        run_pass("R8_slave_gap", 0, 1);

        // R2: window before time mark
        clear_list();
        put(0, 1, 0, 8'h5E); put(1, 0, 0, 8'h5F); put(2, 6, 0, 8'h60);
        run_pass("R2_window_first", 0, 0);

        // R3: master cycle end with no reference entry
        clear_list();
        put(0, 0, 0, 8'h33); put(1, 6, 0, 8'h34);
        run_pass("R3_unpaired_cycle", 1, 0);

        // R3: other entry after open reference
        clear_list();
        put(0, 0, 0, 8'h35); put(1, 5, 0, 8'h36); put(2, 3, 0, 8'h37);
        run_pass("R3_ref_then_win", 1, 0);

        // R3: gap flag mismatch
        clear_list();
        put(0, 5, 0, 8'h38); put(1, 6, 1, 8'h39);
        run_pass("R3_flag_mismatch", 1, 0);

        // R4: slave reference entry
        clear_list();
        put(0, 0, 0, 8'h3A); put(1, 5, 0, 8'h3B); put(2, 6, 0, 8'h3C);
        run_pass("R4_slave_ref", 0, 0);

        // R5: illegal code 7
        clear_list();
        put(0, 0, 0, 8'h3D); put(1, 7, 0, 8'h3E);
        run_pass("R5_code7", 0, 0);

        // R6: full list with no terminator
        clear_list();
        for (int i = 0; i < DEPTH; i++) put(i, 0, 0, 8'hE0 + i);
        run_pass("R6_no_end", 0, 0);

        // R10: error stays set
        repeat (5) @(negedge clk);
        chk("R10", "seq_err held", seq_err, 1);
        chk("R10", "done low", done, 0);
        chk("R10", "cfg_mark held", cfg_mark, 8'hE7);

        // R9: gap master list arms the emergency reference
        clear_list();
        put(0, 0, 0, 8'h0A); put(1, 5, 1, 8'h0B); put(2, 6, 1, 8'h0C);
        put(3, 5, 0, 8'h5A); put(4, 6, 0, 8'h0D);
        run_pass("R9_gap_emerg", 1, 1);
        chk("R9", "emerg_req idle", emerg_req, 0);
        sync_timeout = 1'b1;
        @(negedge clk);
        chk("R9", "emerg_req on timeout", emerg_req, 1);
        sync_timeout = 1'b0;
        @(negedge clk);
        chk("R9", "emerg_req after timeout", emerg_req, 0);

        // R9: next start disarms
        clear_list();
        put(0, 6, 0, 8'h4C);
        run_pass("R9_disarm_pass", 0, 0);
        sync_timeout = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9", "emerg_req disarmed", emerg_req, 0);
        sync_timeout = 1'b0;

        repeat (3) @(negedge clk);
        chk("R1", "queue drained", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule